// File: doc/BRIEF.md
# DTMF Digit Serial Readout Multiplexer

This block sits behind a tone decoder and its guard-time logic. When the guard-time logic strobes a decoded 4-bit key code, the block captures it. An external host then reads the code one bit per acknowledge pulse on a single serial data pin. The pin is shared. Whenever no readout is in progress, it carries the call-progress energy-detect flag, so the host can watch for supervisory tones on the same wire.

The host drives the acknowledge clock from its own timebase. That clock runs up to 1 MHz, with a 40 to 60 percent duty cycle. The block brings it through a synchroniser into the system clock domain and acts on its rising and falling edges there. The captured code stays frozen while it is being read. A strobe that arrives mid-readout waits in a one-entry slot until the current code has been read out.

Top module: `dtmf_serial_mux`

## Requirements
- R1: After reset no code is held, the pending slot is empty and `sd_o` shows `cp_flag_i`.
- R2: While no code is being read (none held, or held with no acknowledge rise yet), `sd_o` equals `cp_flag_i` in the same cycle.
- R3: A `load_i` strobe when no readout is in progress captures `code_i`. This includes replacing a held code that has not yet seen a rise.
- R4: A rising edge of `ack_i` sampled at clock edge k changes `sd_o` right after edge k+2, and not before.
- R5: After the n-th acknowledge rise (n = 1..4) of a readout, `sd_o` shows bit n-1 of the held code, least significant bit first.
- R6: The fourth bit stays on `sd_o` until `ack_i` falls. At that point the code is released and `sd_o` returns to `cp_flag_i`, unless a new code is loaded in the same step.
- R7: A strobe arriving during a readout does not alter the bits being shifted out.
- R8: A strobe during a readout is kept pending, with the latest strobe winning. The pending code becomes the held code when the readout ends.
- R9: A strobe in the same cycle as the readout-ending falling edge becomes the held code, and any pending code is dropped.
- R10: Acknowledge edges while no code is held are ignored. The pin stays on `cp_flag_i`, and a later code still reads out from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| code_i | input | CODE_W | Decoded key code from the guard-time logic |
| load_i | input | 1 | One-cycle strobe that presents `code_i` |
| ack_i | input | 1 | Asynchronous acknowledge clock from the host |
| cp_flag_i | input | 1 | Call-progress energy-detect flag |
| sd_o | output | 1 | Shared serial data / call-progress pin |

## Verification
A load strobe can land in the very cycle in which the synchronised falling acknowledge edge ends a readout. In that cycle the end of the readout and a new capture compete for the holding register. The bench provokes this by counting synchroniser stages from the instant it drops `ack_i` and placing the strobe exactly on the cycle of the release. It does this both with and without a code already pending. It judges the outcome by requiring `sd_o` to show the call-progress flag next, and the following four acknowledge pulses to shift out the strobed code rather than the pending one.

// File: rtl/dtmf_ser_pkg.sv
package dtmf_ser_pkg;

    localparam int DEF_CODE_W      = 4;
    localparam int DEF_SYNC_STAGES = 2;

    typedef struct packed {
        logic rise;
        logic fall;
    } ack_ev_t;

endpackage

// File: rtl/ack_edge_sync.sv
module ack_edge_sync
    import dtmf_ser_pkg::*;
#(
    parameter int STAGES = DEF_SYNC_STAGES
) (
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    ack_i,
    output ack_ev_t ev_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], ack_i};
        st_d.last  = st_q.chain[STAGES-1];
        ev_o.rise  = st_q.chain[STAGES-1] & ~st_q.last;
        ev_o.fall  = ~st_q.chain[STAGES-1] & st_q.last;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pend_slot.sv
module pend_slot #(
    parameter int CODE_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              capture_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              clear_i,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o
);

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.valid = 1'b0;
        end
        if (capture_i) begin
            st_d.valid = 1'b1;
            st_d.code  = code_i;
        end
        valid_o = st_q.valid;
        code_o  = st_q.code;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/readout_seq.sv
module readout_seq #(
    parameter int CODE_W = 4,
    localparam int CNT_W = $clog2(CODE_W + 1),
    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ld_valid_i,
    input  logic [CODE_W-1:0] ld_code_i,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              held_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CODE_W-1:0] code_o,
    output logic              show_o,
    output logic              bit_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W);

    typedef struct packed {
        logic              held;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] code;
    } st_t;

    st_t st_d, st_q;
    logic [IDX_W-1:0] idx;

    always_comb begin
        st_d   = st_q;
        done_o = fall_i && st_q.held && (st_q.cnt == LAST);

        if (rise_i && st_q.held && (st_q.cnt < LAST)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (done_o) begin
            st_d.held = 1'b0;
            st_d.cnt  = '0;
        end
        if (ld_valid_i) begin
            st_d.held = 1'b1;
            st_d.cnt  = '0;
            st_d.code = ld_code_i;
        end

        idx    = IDX_W'(st_q.cnt - CNT_W'(1));
        busy_o = (st_q.cnt != '0);
        held_o = st_q.held;
        cnt_o  = st_q.cnt;
        code_o = st_q.code;
        show_o = st_q.held && (st_q.cnt != '0);
        bit_o  = st_q.code[idx];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dtmf_serial_mux.sv
module dtmf_serial_mux
    import dtmf_ser_pkg::*;
#(
    parameter int CODE_W      = DEF_CODE_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int CNT_W      = $clog2(CODE_W + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_i,
    input  logic              load_i,
    input  logic              ack_i,
    input  logic              cp_flag_i,
    output logic              sd_o
);

    ack_ev_t           ack_ev;
    logic              pend_valid;
    logic [CODE_W-1:0] pend_code;
    logic              rd_busy;
    logic              rd_done;
    logic              rd_held;
    logic [CNT_W-1:0]  rd_cnt;
    logic [CODE_W-1:0] rd_code;
    logic              rd_show;
    logic              rd_bit;
    logic              ld_valid;
    logic [CODE_W-1:0] ld_code;
    logic              pend_capture;

    ack_edge_sync #(
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ack_i (ack_i),
        .ev_o  (ack_ev)
    );

    always_comb begin
        pend_capture = load_i && rd_busy && !rd_done;
        ld_valid     = 1'b0;
        ld_code      = code_i;
        if (load_i && (!rd_busy || rd_done)) begin
            ld_valid = 1'b1;
        end else if (rd_done && pend_valid) begin
            ld_valid = 1'b1;
            ld_code  = pend_code;
        end
        sd_o = rd_show ? rd_bit : cp_flag_i;
    end

    pend_slot #(
        .CODE_W(CODE_W)
    ) pend_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .capture_i(pend_capture),
        .code_i   (code_i),
        .clear_i  (rd_done),
        .valid_o  (pend_valid),
        .code_o   (pend_code)
    );

    readout_seq #(
        .CODE_W(CODE_W)
    ) seq_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ld_valid_i(ld_valid),
        .ld_code_i (ld_code),
        .rise_i    (ack_ev.rise),
        .fall_i    (ack_ev.fall),
        .busy_o    (rd_busy),
        .done_o    (rd_done),
        .held_o    (rd_held),
        .cnt_o     (rd_cnt),
        .code_o    (rd_code),
        .show_o    (rd_show),
        .bit_o     (rd_bit)
    );

endmodule

// File: rtl/dtmf_serial_mux_chk.sv
module dtmf_serial_mux_chk #(
    parameter int CODE_W = 4,
    localparam int CNT_W = $clog2(CODE_W + 1)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rise,
    input logic              held,
    input logic [CNT_W-1:0]  cnt,
    input logic [CODE_W-1:0] code,
    input logic              pend,
    input logic              load_i,
    input logic              done,
    input logic              sd_o,
    input logic              cp_flag_i
);

    p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt <= CNT_W'(CODE_W));

    p_idle_cp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!held || cnt == '0) |-> (sd_o == cp_flag_i));

    p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise && cnt != '0 && cnt < CNT_W'(CODE_W)) |=> (cnt == $past(cnt) + CNT_W'(1)));

    p_stable_digit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt != '0 && $past(cnt) != '0) |-> $stable(code));

    p_pend_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend |-> (cnt != '0));

    p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done && !load_i && !pend) |=> !held);

    p_idle_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!held && !load_i && !done) |=> !held);

endmodule

bind dtmf_serial_mux dtmf_serial_mux_chk #(.CODE_W(CODE_W)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise     (ack_ev.rise),
    .held     (rd_held),
    .cnt      (rd_cnt),
    .code     (rd_code),
    .pend     (pend_valid),
    .load_i   (load_i),
    .done     (rd_done),
    .sd_o     (sd_o),
    .cp_flag_i(cp_flag_i)
);

// File: tb/dtmf_serial_mux_tb_top.sv
module dtmf_serial_mux_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] code = '0;
    logic          load = 1'b0;
    logic          ack = 1'b0;
    logic          cp = 1'b0;
    logic          sd;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    bit          m_held = 0;
    int          m_cnt = 0;
    logic [CW-1:0] m_code = '0;
    bit          m_pend = 0;
    logic [CW-1:0] m_pcode = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtmf_serial_mux #(.CODE_W(CW)) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .code_i   (code),
        .load_i   (load),
        .ack_i    (ack),
        .cp_flag_i(cp),
        .sd_o     (sd)
    );

    function automatic logic exp_sd();
        if (m_held && m_cnt != 0) return m_code[m_cnt-1];
        return cp;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: sd_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_cp(input logic v, input string req);
        cp = v;
        #1;
        chk(req, sd, exp_sd());
    endtask

    task automatic do_load(input logic [CW-1:0] c);
        @(negedge clk);
        code = c;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        if (!m_held || m_cnt == 0) begin
            m_held = 1; m_cnt = 0; m_code = c;
        end else begin
            m_pend = 1; m_pcode = c;
        end
        chk("R3/R7/R8 load", sd, exp_sd());
    endtask

    task automatic ack_rise();
        logic old;
        @(negedge clk);
        old = exp_sd();
        ack = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R4 no early change", sd, old);
        @(negedge clk);
        if (m_held && m_cnt < CW) m_cnt++;
        chk("R5 bit after rise", sd, exp_sd());
        @(negedge clk);
    endtask

    task automatic ack_fall();
        @(negedge clk);
        ack = 1'b0;
        repeat (3) @(negedge clk);
        if (m_held && m_cnt == CW) begin
            if (m_pend) begin
                m_code = m_pcode; m_cnt = 0; m_pend = 0;
            end else begin
                m_held = 0; m_cnt = 0;
            end
        end
        chk("R6 after fall", sd, exp_sd());
        @(negedge clk);
    endtask

    task automatic pulse();
        ack_rise();
        ack_fall();
    endtask

    // strobe placed on the exact cycle the falling edge ends readout (R9)
    task automatic fall_with_load(input logic [CW-1:0] c);
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        @(negedge clk);
        code = c;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        m_held = 1; m_cnt = 0; m_code = c; m_pend = 0;
        chk("R9 same-cycle load shows cp", sd, exp_sd());
        @(negedge clk);
    endtask

    task automatic read_all(input string req, input logic [CW-1:0] c);
        for (int i = 0; i < CW; i++) begin
            ack_rise();
            chk(req, sd, c[i]);
            if (i < CW - 1) ack_fall();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: expired expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        set_cp(1'b1, "R1 reset shows cp");
        set_cp(1'b0, "R1 reset shows cp");
        // R10 ack with no code held
        pulse();
        set_cp(1'b1, "R10 idle ack ignored");
        // R2/R3 load, pin still cp, replace before first rise
        do_load(4'hA);
        set_cp(1'b0, "R2 held no rise shows cp");
        do_load(4'h6);
        set_cp(1'b1, "R2 held no rise shows cp");
        // R5 LSB first; R7/R8 strobes during readout, latest wins
        ack_rise();
        chk("R5 bit0 of 6", sd, 1'b0);
        ack_fall();
        do_load(4'h3);
        ack_rise();
        chk("R7 bit1 of 6 unaffected", sd, 1'b1);
        do_load(4'h9);
        ack_fall();
        ack_rise();
        chk("R7 bit2 of 6", sd, 1'b1);
        ack_fall();
        ack_rise();
        chk("R6 bit3 held until fall", sd, 1'b0);
        ack_fall();
        chk("R8 pending becomes held", {1'b0, m_code == 4'h9 && m_held}, 1'b1);
        set_cp(1'b1, "R8 pending held shows cp");
        read_all("R8 pending code read", 4'h9);
        // R9 same-cycle load at release, with pending present
        do_load(4'h5);
        fall_with_load(4'hC);
        set_cp(1'b0, "R9 cp after same-cycle load");
        read_all("R9 strobed code wins", 4'hC);
        // R9 without pending
        fall_with_load(4'h7);
        read_all("R9 no pending", 4'h7);
        ack_fall();
        set_cp(1'b1, "R6 released shows cp");
        set_cp(1'b0, "R6 released shows cp");
        // random phase
        for (int it = 0; it < 60; it++) begin
            int np;
            set_cp(1'($urandom_range(0, 1)), "R2 random cp");
            if ($urandom_range(0, 2) != 0) do_load(CW'($urandom_range(0, 15)));
            np = $urandom_range(0, 6);
            for (int p = 0; p < np; p++) begin
                ack_rise();
                if ($urandom_range(0, 3) == 0) do_load(CW'($urandom_range(0, 15)));
                if ($urandom_range(0, 3) == 0) set_cp(~cp, "R2/R5 random cp");
                ack_fall();
            end
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule